// File: doc/BRIEF.md
# Dual-Role Byte Serial Port with Mode Fault

This block exchanges one byte at a time over a four-wire synchronous serial link. It can act as the clocking end of the link (master) or the clocked end (slave). During a transfer, eight bits leave on one data line and eight bits arrive on the other, most significant bit first. Software controls it through a small register-style port. A control word chooses the role, the SCK polarity and phase, and the master clock rate. A data write loads the byte to send; in master mode the same write starts the transfer. A read buffer holds the last byte received. Three sticky status bits report completion, a write collision and a mode fault.

In master mode the block drives SCK and MOSI. It also watches its own slave-select input. If that input goes low while the block is mastering, the block drops out of the master role at once. In slave mode SCK, MOSI and slave-select come from outside and pass through synchronizers. MISO is driven only while the block is enabled as a slave and selected. Each pin has separate output and output-enable signals so that a pad ring can build the tri-state buffer.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, the control readback, all three flags, `busy` and every output enable are 0. The control word is laid out as bit 5 enable, bit 4 master, bit 3 CPOL, bit 2 CPHA, bits 1:0 rate, and a control write is read back unchanged on `ctrlRd`.
- R2: In master mode, a data write while idle starts a transfer of exactly 16 SCK transitions. The byte goes out MSB first on MOSI, and the byte sampled from MISO, MSB first, appears on `rxData`.
- R3: SCK rests at the CPOL level when idle. The leading edge is the transition away from CPOL. With CPHA=0 data is sampled on leading edges; with CPHA=1 it is sampled on trailing edges.
- R4: In master mode with CPHA=0, MOSI carries the first bit for one half SCK period before the first SCK edge. With CPHA=1, MOSI changes on leading edges.
- R5: The master SCK half period is 1, 2, 8 or 16 system clocks for rate codes 0, 1, 2 and 3.
- R6: In slave mode the block samples MOSI and shifts out on MISO using the outside SCK. It exchanges a full byte for every mode, whatever the rate code.
- R7: `misoOe` is 1 only when the block is enabled, in slave mode, and `ssN` is low; it follows `ssN` with no delay.
- R8: On the eighth sampled bit, the received byte is copied to `rxData` and `doneFlag` is set. The flag stays set until `statClr` is pulsed.
- R9: A data write while `busy` is high sets `collFlag` (cleared by `statClr`) and does not change the byte being sent.
- R10: When `ssN` goes low while the block is enabled as master, `faultFlag` is set and the master bit in the control word is cleared. `sckOe` and `mosiOe` drop, the transfer stops without setting `doneFlag`, and `faultFlag` stays set until `faultClr` is pulsed. `statClr` does not clear it.
- R11: In slave mode with CPHA=0, MISO shows the MSB of the loaded byte as soon as `ssN` falls, before any SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWdata | input | 6 | Control word to write |
| ctrlRd | output | 6 | Current control word |
| dataWr | input | 1 | Data write strobe (starts a transfer in master mode) |
| dataWdata | input | 8 | Byte to transmit |
| rxData | output | 8 | Last complete received byte |
| statClr | input | 1 | Clears done and collision flags |
| faultClr | input | 1 | Clears the mode fault flag |
| doneFlag | output | 1 | Transfer complete |
| collFlag | output | 1 | Write collision |
| faultFlag | output | 1 | Mode fault |
| busy | output | 1 | Transfer in progress or slave selected |
| sckIn | input | 1 | SCK from outside (slave) |
| sckOut | output | 1 | SCK driven (master) |
| sckOe | output | 1 | SCK output enable |
| mosiIn | input | 1 | MOSI from outside (slave) |
| mosiOut | output | 1 | MOSI driven (master) |
| mosiOe | output | 1 | MOSI output enable |
| misoIn | input | 1 | MISO from outside (master) |
| misoOut | output | 1 | MISO driven (slave) |
| misoOe | output | 1 | MISO output enable |
| ssN | input | 1 | Slave select, active low |

## Verification
The assertions assume that the outside SCK, MOSI and slave-select change slowly enough for the two-stage synchronizers to see every level, and that the control word is not rewritten during a transfer. The stimulus holds each outside SCK level for eight system clocks. It changes MOSI half a period away from the sampling edge. It writes the control word only while the block is idle. Slave-select is kept high in master mode except in the single mode-fault scenario.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam int CTRL_W = 6;

  typedef struct packed {
    logic       en;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } strobe_t;

  // half SCK period in system clocks for each rate code
  function automatic logic [4:0] halfOf(input logic [1:0] code);
    case (code)
      2'd0:    halfOf = 5'd1;
      2'd1:    halfOf = 5'd2;
      2'd2:    halfOf = 5'd8;
      default: halfOf = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlWr,
  input  ctrl_t   ctrlWdata,
  input  logic    dataWr,
  input  logic    statClr,
  input  logic    faultClr,
  input  logic    sckIn,
  input  logic    mosiIn,
  input  logic    misoIn,
  input  logic    ssN,
  output ctrl_t   ctrlQ,
  output strobe_t strb,
  output logic    serIn,
  output logic    sckOut,
  output logic    busy,
  output logic    doneFlag,
  output logic    collFlag,
  output logic    faultFlag
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  logic [SYNC_N-1:0] sckSh, ssSh, mosiSh;
  logic sckS, sckPrev, ssLow;
  logic mBusy, sckQ;
  logic [4:0] halfCnt, halfLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0] sampCnt;
  logic doneQ, collQ, faultQ;
  logic faultEvt, sSel, loadEvt, startM, collEvt, tick;
  logic leadM, trailM, sEdge, leadS, trailS, lead, trail;
  logic sampleEvt, shiftEvt, finishEvt;

  // input synchronizers for the slave-side pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSh   <= '0;
      ssSh    <= '1;
      mosiSh  <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSh   <= {sckSh[SYNC_N-2:0], sckIn};
      ssSh    <= {ssSh[SYNC_N-2:0], ssN};
      mosiSh  <= {mosiSh[SYNC_N-2:0], mosiIn};
      sckPrev <= sckS;
    end
  end

  assign sckS  = sckSh[SYNC_N-1];
  assign ssLow = ~ssSh[SYNC_N-1];

  assign faultEvt = ctrlQ.en & ctrlQ.master & ssLow;
  assign sSel     = ctrlQ.en & ~ctrlQ.master & ssLow;
  assign busy     = mBusy | sSel;
  assign loadEvt  = dataWr & ~busy & ~faultEvt;
  assign startM   = loadEvt & ctrlQ.en & ctrlQ.master;
  assign collEvt  = dataWr & busy;
  assign halfLim  = halfOf(ctrlQ.rate);
  assign tick     = mBusy & (halfCnt == halfLim - 5'd1) & ~faultEvt;

  // edge classification: master from own divider, slave from synced SCK
  assign leadM  = tick & ~edgeCnt[0];
  assign trailM = tick & edgeCnt[0];
  assign sEdge  = sSel & (sckS != sckPrev);
  assign leadS  = sEdge & (sckS != ctrlQ.cpol);
  assign trailS = sEdge & (sckS == ctrlQ.cpol);
  assign lead   = ctrlQ.master ? leadM : leadS;
  assign trail  = ctrlQ.master ? trailM : trailS;

  assign sampleEvt = ctrlQ.cpha ? trail : lead;
  assign shiftEvt  = ctrlQ.cpha ? (lead & (sampCnt != '0)) : trail;
  assign finishEvt = sampleEvt & (sampCnt == CNT_W'(DATA_W - 1));

  // master clock generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mBusy   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckQ    <= 1'b0;
    end else if (faultEvt) begin
      mBusy   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckQ    <= ctrlQ.cpol;
    end else if (!mBusy) begin
      sckQ    <= ctrlQ.cpol;
      halfCnt <= '0;
      edgeCnt <= '0;
      if (startM) mBusy <= 1'b1;
    end else if (tick) begin
      sckQ    <= ~sckQ;
      halfCnt <= '0;
      edgeCnt <= edgeCnt + 1'b1;
      if (edgeCnt == EDGE_W'(2 * DATA_W - 1)) mBusy <= 1'b0;
    end else begin
      halfCnt <= halfCnt + 5'd1;
    end
  end

  // bit counter shared by both roles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampCnt <= '0;
    end else if (!mBusy && !sSel) begin
      sampCnt <= '0;
    end else if (sampleEvt) begin
      sampCnt <= finishEvt ? '0 : sampCnt + 1'b1;
    end
  end

  // control word and sticky flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      doneQ  <= 1'b0;
      collQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrlWdata;
      if (faultEvt) ctrlQ.master <= 1'b0;
      doneQ  <= finishEvt | (doneQ & ~statClr);
      collQ  <= collEvt | (collQ & ~statClr);
      faultQ <= faultEvt | (faultQ & ~faultClr);
    end
  end

  assign strb      = '{load: loadEvt, shift: shiftEvt, sample: sampleEvt, finish: finishEvt};
  assign serIn     = ctrlQ.master ? misoIn : mosiSh[SYNC_N-1];
  assign sckOut    = sckQ;
  assign doneFlag  = doneQ;
  assign collFlag  = collQ;
  assign faultFlag = faultQ;

  // R10
  fault_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.en && ctrlQ.master && ssLow) |=> (faultQ && !ctrlQ.master && !mBusy));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && !faultClr) |=> faultQ);

  // R9
  coll_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busy) |=> collQ);

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> doneQ);

  // R2
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    mBusy |-> (edgeCnt < EDGE_W'(2 * DATA_W)));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mBusy |=> (sckOut == $past(ctrlQ.cpol)));

endmodule

// File: rtl/spi_xcvr_dpath.sv
module spi_xcvr_dpath
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              serIn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txSh, rxSh, rxBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (strb.load) begin
      txSh <= wdata;
    end else if (strb.shift) begin
      txSh <= {txSh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh  <= '0;
      rxBuf <= '0;
    end else if (strb.sample) begin
      rxSh <= {rxSh[DATA_W-2:0], serIn};
      if (strb.finish) rxBuf <= {rxSh[DATA_W-2:0], serIn};
    end
  end

  assign txBit  = txSh[DATA_W-1];
  assign rxData = rxBuf;

  // R9
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.shift);

  // R8
  finish_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> strb.sample);

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRd,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] rxData,
  input  logic              statClr,
  input  logic              faultClr,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              faultFlag,
  output logic              busy,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);

  ctrl_t   ctrlQ;
  strobe_t strb;
  logic    serIn, txBit;

  spi_xcvr_ctrl #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(ctrlWr), .ctrlWdata(ctrl_t'(ctrlWdata)),
    .dataWr(dataWr), .statClr(statClr), .faultClr(faultClr),
    .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn), .ssN(ssN),
    .ctrlQ(ctrlQ), .strb(strb), .serIn(serIn), .sckOut(sckOut),
    .busy(busy), .doneFlag(doneFlag), .collFlag(collFlag), .faultFlag(faultFlag)
  );

  spi_xcvr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(dataWdata),
    .serIn(serIn), .txBit(txBit), .rxData(rxData)
  );

  assign ctrlRd  = ctrlQ;
  assign sckOe   = ctrlQ.en & ctrlQ.master;
  assign mosiOe  = ctrlQ.en & ctrlQ.master;
  assign misoOe  = ctrlQ.en & ~ctrlQ.master & ~ssN;
  assign mosiOut = txBit;
  assign misoOut = txBit;

endmodule

// File: tb/sim_spi_xcvr.sv
module sim_spi_xcvr;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0, dataWr = 1'b0, statClr = 1'b0, faultClr = 1'b0;
  logic [5:0] ctrlWdata = '0, ctrlRd;
  logic [7:0] dataWdata = '0, rxData;
  logic doneFlag, collFlag, faultFlag, busy;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssN = 1'b1;
  logic sckOut, sckOe, mosiOut, mosiOe, misoIn, misoOut, misoOe;

  int nCmp = 0, nBad = 0;
  logic [7:0] expQ[$];
  logic donePrev = 1'b0;

  // bench-side slave model for master tests
  logic bslvOn = 1'b0, bcpol = 1'b0, bcpha = 1'b0, leadB;
  logic [7:0] slvTx = '0, slvRx = '0;
  int slvCnt = 0;
  int edgeN = 0;
  time edgeT[0:39];

  always #10 clk = ~clk;

  spi_xcvr u0 (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata), .ctrlRd(ctrlRd),
    .dataWr(dataWr), .dataWdata(dataWdata), .rxData(rxData), .statClr(statClr),
    .faultClr(faultClr), .doneFlag(doneFlag), .collFlag(collFlag), .faultFlag(faultFlag),
    .busy(busy), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut),
    .misoOe(misoOe), .ssN(ssN)
  );

  assign misoIn = slvTx[7];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(sckOut) begin
    if (edgeN < 40) edgeT[edgeN] = $time;
    edgeN++;
    if (bslvOn) begin
      leadB = (sckOut != bcpol);
      if (bcpha ? !leadB : leadB) begin
        slvRx = {slvRx[6:0], mosiOut};
        slvCnt++;
      end
      if (bcpha ? (leadB && slvCnt != 0) : !leadB) slvTx = {slvTx[6:0], 1'b0};
    end
  end

  // scoreboard monitor: compare received byte on each completion
  always @(negedge clk) begin
    if (rstN && doneFlag && !donePrev) begin
      if (expQ.size() == 0) chk("R8 unexpected completion", 1, 0);
      else chk("R8 rxData vs scoreboard", rxData, expQ.pop_front());
    end
    donePrev = doneFlag;
  end

  task automatic writeCtrl(input logic en, ms, cpol, cpha, input logic [1:0] rate);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlWdata = {en, ms, cpol, cpha, rate};
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic writeData(input logic [7:0] b);
    @(negedge clk);
    dataWr = 1'b1; dataWdata = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic pulseStat();
    @(negedge clk); statClr = 1'b1;
    @(negedge clk); statClr = 1'b0;
  endtask

  task automatic masterXfer(input logic cpol, cpha, input logic [1:0] rate,
                            input logic [7:0] txb, slvb);
    int half;
    half = (rate == 0) ? 1 : (rate == 1) ? 2 : (rate == 2) ? 8 : 16;
    bslvOn = 1'b0;
    writeCtrl(1'b1, 1'b1, cpol, cpha, rate);
    repeat (2) @(negedge clk);
    chk("R3 idle SCK equals CPOL", sckOut, cpol);
    bcpol = cpol; bcpha = cpha; slvTx = slvb; slvRx = '0; slvCnt = 0;
    edgeN = 0; bslvOn = 1'b1;
    expQ.push_back(slvb);
    writeData(txb);
    chk("R4 no SCK edge before half period", edgeN, 0);
    if (!cpha) chk("R4 first bit on MOSI ahead of edge", mosiOut, txb[7]);
    for (int k = 0; k < 2000 && edgeN < 16; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2 sixteen SCK transitions", edgeN, 16);
    chk("R5 half period in clocks", (edgeT[1] - edgeT[0]) / 20, half);
    chk("R2 byte seen by slave on MOSI", slvRx, txb);
    chk("R3 SCK back at CPOL", sckOut, cpol);
    chk("R8 done flag after master byte", doneFlag, 1);
    bslvOn = 1'b0;
    pulseStat();
    chk("R8 statClr clears done", doneFlag, 0);
  endtask

  task automatic slaveXfer(input logic cpol, cpha, input logic [1:0] rate,
                           input logic [7:0] dutTx, mstTx);
    logic [7:0] capt;
    capt = '0;
    sckIn = cpol;
    writeCtrl(1'b1, 1'b0, cpol, cpha, rate);
    writeData(dutTx);
    chk("R7 MISO released while deselected", misoOe, 0);
    @(negedge clk); ssN = 1'b0;
    #1;
    chk("R7 MISO enabled on select", misoOe, 1);
    repeat (4) @(negedge clk);
    if (!cpha) chk("R11 MSB on MISO before first edge", misoOut, dutTx[7]);
    expQ.push_back(mstTx);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosiIn = mstTx[7 - i];
        repeat (8) @(negedge clk);
        capt = {capt[6:0], misoOut};
        sckIn = ~cpol;
        repeat (8) @(negedge clk);
        sckIn = cpol;
      end else begin
        repeat (8) @(negedge clk);
        sckIn = ~cpol;
        mosiIn = mstTx[7 - i];
        repeat (8) @(negedge clk);
        capt = {capt[6:0], misoOut};
        sckIn = cpol;
      end
    end
    repeat (12) @(negedge clk);
    chk("R6 byte shifted out on MISO", capt, dutTx);
    chk("R8 done flag after slave byte", doneFlag, 1);
    ssN = 1'b1;
    #1;
    chk("R7 MISO released on deselect", misoOe, 0);
    repeat (4) @(negedge clk);
    pulseStat();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl after reset", ctrlRd, 0);
    chk("R1 sckOe after reset", sckOe, 0);
    chk("R1 mosiOe after reset", mosiOe, 0);
    chk("R1 misoOe after reset", misoOe, 0);
    chk("R1 flags after reset", {doneFlag, collFlag, faultFlag, busy}, 0);
    writeCtrl(1'b1, 1'b0, 1'b1, 1'b1, 2'b01);
    chk("R1 control readback", ctrlRd, 6'h2D);
    chk("R7 slave deselected keeps MISO off", misoOe, 0);

    // R2 R3 R4 R5 master exchanges in all four modes
    masterXfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
    masterXfer(1'b0, 1'b1, 2'd1, 8'h5A, 8'hC3);
    masterXfer(1'b1, 1'b0, 2'd2, 8'h81, 8'h7E);
    masterXfer(1'b1, 1'b1, 2'd3, 8'hF0, 8'h0F);

    // R9 write collision during a master transfer
    writeCtrl(1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
    repeat (2) @(negedge clk);
    bcpol = 1'b0; bcpha = 1'b0; slvTx = 8'h99; slvRx = '0; slvCnt = 0;
    edgeN = 0; bslvOn = 1'b1;
    expQ.push_back(8'h99);
    writeData(8'hC6);
    repeat (10) @(negedge clk);
    writeData(8'h3B);
    chk("R9 collision flag set", collFlag, 1);
    for (int k = 0; k < 2000 && edgeN < 16; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 colliding write ignored", slvRx, 8'hC6);
    bslvOn = 1'b0;
    pulseStat();
    chk("R9 statClr clears collision", collFlag, 0);

    // R10 mode fault while mastering
    writeCtrl(1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
    repeat (2) @(negedge clk);
    bcpol = 1'b0; bcpha = 1'b0; slvTx = 8'h55; slvRx = '0; slvCnt = 0;
    edgeN = 0; bslvOn = 1'b1;
    writeData(8'hE7);
    repeat (20) @(negedge clk);
    ssN = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 fault flag set", faultFlag, 1);
    chk("R10 master bit cleared", ctrlRd[4], 0);
    chk("R10 SCK driver released", sckOe, 0);
    chk("R10 MOSI driver released", mosiOe, 0);
    ssN = 1'b1;
    repeat (600) @(negedge clk);
    chk("R10 aborted transfer sets no done", doneFlag, 0);
    chk("R10 aborted transfer not busy", busy, 0);
    pulseStat();
    chk("R10 fault survives statClr", faultFlag, 1);
    @(negedge clk); faultClr = 1'b1;
    @(negedge clk); faultClr = 1'b0;
    chk("R10 faultClr clears flag", faultFlag, 0);
    bslvOn = 1'b0;

    // R6 R7 R11 slave exchanges, rate code varied
    slaveXfer(1'b0, 1'b0, 2'd0, 8'hD2, 8'h4B);
    slaveXfer(1'b1, 1'b1, 2'd3, 8'h69, 8'h96);
    slaveXfer(1'b0, 1'b1, 2'd2, 8'hE1, 8'h1E);
    slaveXfer(1'b1, 1'b0, 2'd1, 8'hB4, 8'h2D);

    repeat (5) @(negedge clk);
    chk("R8 scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule